// File: doc/BRIEF.md
# Serial Drive Configuration Register

This block is the per-channel configuration port of a motor chopper controller. A host sends a 16-bit frame over three wires: a data line, a shift clock and a strobe. The block collects the frame in a shift register and passes it through a holding stage. That stage follows the shift register while the strobe is low and freezes on the strobe rising edge. The held word is split into five drive settings: blanking length select, torque range, decay mode, a 5-bit current code and a direction bit.

A mode input picks where two of those settings come from. In serial mode every field comes from the held word. In pin-PWM mode only the low seven bits (blanking, torque, decay) take effect. The current code is then forced to full scale, and direction follows an external phase pin. A sleep input clears both the shift register and the holding stage to their default word.

All three serial wires are treated as levels that are already synchronous to the system clock. The block detects their edges by comparing each sample with the one taken in the cycle before.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, the held word is 0x0FB8. This means blanking select 0, torque 3, decay 1, current 31 and direction 0 (with mode high).
- R2: Each rising edge of `ser_clk` shifts `ser_data` into bit 15 of the shift register and moves every bit one place toward bit 0. After 16 edges, the first bit sent sits in bit 0.
- R3: While `ser_strobe` is low, the held word follows the shift register. It shows the new contents one clock after each shift edge.
- R4: While `ser_strobe` is high, the held word keeps the value captured at the strobe rising edge, even if the shift clock keeps toggling.
- R5: The fields of the held word are decoded as follows:
  - bits 2:0 give `blank_sel`;
  - bits 4:3 give `torque_sel`;
  - bits 6:5 give `decay_sel`;
  - bits 11:7 give `current_code`;
  - bit 12 gives the direction (1 = positive).
- R6: With `mode_serial` low, `current_code` is 31 and `dir_out` equals `phase_in`. Blanking, torque and decay still come from the held word.
- R7: With `mode_serial` high, `current_code` and `dir_out` come from bits 11:7 and bit 12 of the held word.
- R8: Asserting `sleep` for one clock returns the shift register and the held word to 0x0FB8.
- R9: Bits 15:13 of the held word affect no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep | input | 1 | Synchronous clear of all configuration state, active high |
| ser_clk | input | 1 | Serial shift clock (synchronised level) |
| ser_data | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Holding stage control: low = follow, rising edge = capture |
| mode_serial | input | 1 | 1 = serial direction/current, 0 = pin-PWM control |
| phase_in | input | 1 | External direction pin used in pin-PWM mode |
| blank_sel | output | 3 | Blanking length select |
| torque_sel | output | 2 | Torque range select |
| decay_sel | output | 2 | Decay mode select |
| current_code | output | 5 | Current code to the DAC |
| dir_out | output | 1 | Bridge direction, 1 = positive |

## Verification
The assertions check the following on every cycle:
- the shift direction and entry point;
- that the held word is frozen while the strobe is high;
- that the held word tracks the shift register while the strobe is low;
- the clear to the default word after sleep;
- the forcing of current and direction in pin-PWM mode.

The bench's scenarios show the end-to-end behaviour:
- that a whole frame sent lowest bit first lands as the intended settings;
- that unused top bits change nothing;
- that a frame shifted during a high strobe stays invisible until the next low phase.

// File: rtl/sdcr_pkg.sv
package sdcr_pkg;
    localparam int FRAME_W   = 16;
    localparam int BLANK_W   = 3;
    localparam int TORQ_W    = 2;
    localparam int DECAY_W   = 2;
    localparam int CUR_W     = 5;
    localparam int BLANK_LSB = 0;
    localparam int TORQ_LSB  = BLANK_LSB + BLANK_W;
    localparam int DECAY_LSB = TORQ_LSB + TORQ_W;
    localparam int CUR_LSB   = DECAY_LSB + DECAY_W;
    localparam int DIR_BIT   = CUR_LSB + CUR_W;
    localparam int USED_W    = DIR_BIT + 1;

    localparam logic [FRAME_W-1:0] RESET_WORD = 16'h0FB8;

    typedef struct packed {
        logic [BLANK_W-1:0] blank;
        logic [TORQ_W-1:0]  torque;
        logic [DECAY_W-1:0] decay;
        logic [CUR_W-1:0]   current;
        logic               dir;
    } fields_t;
endpackage

// File: rtl/sdcr_shifter.sv
module sdcr_shifter
    import sdcr_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         ser_clk,
    input  logic         ser_data,
    output logic [W-1:0] sr_q,
    output logic [W-1:0] sr_next
);
    typedef struct packed {
        logic         clk_prev;
        logic [W-1:0] sr;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.clk_prev = ser_clk;
        if (clear) begin
            st_d.sr = RESET_WORD[W-1:0];
        end else if (ser_clk && !st_q.clk_prev) begin
            st_d.sr = {ser_data, st_q.sr[W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.clk_prev <= 1'b0;
            st_q.sr       <= RESET_WORD[W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign sr_q    = st_q.sr;
    assign sr_next = st_d.sr;

    // R2: a detected shift edge places the sampled data bit at the top
    assert_shift_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !st_q.clk_prev && !clear) |=> (sr_q[W-1] == $past(ser_data)))
        else $error("shift entry mismatch");

    // R2: the rest of the register moves one place toward bit 0
    assert_shift_move_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !st_q.clk_prev && !clear) |=> (sr_q[W-2:0] == $past(sr_q[W-1:1])))
        else $error("shift move mismatch");
endmodule

// File: rtl/sdcr_hold.sv
module sdcr_hold
    import sdcr_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         strobe,
    input  logic [W-1:0] sr_next,
    output logic [W-1:0] word_q
);
    typedef struct packed {
        logic [W-1:0] word;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.word = RESET_WORD[W-1:0];
        end else if (!strobe) begin
            st_d.word = sr_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.word <= RESET_WORD[W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign word_q = st_q.word;

    // R4: a high strobe freezes the held word
    assert_strobe_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clear) |=> $stable(word_q))
        else $error("held word moved while strobe high");

    // R8: sleep returns the held word to its default
    assert_sleep_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (word_q == RESET_WORD[W-1:0]))
        else $error("held word not cleared");
endmodule

// File: rtl/sdcr_decode.sv
module sdcr_decode
    import sdcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [USED_W-1:0] word,
    input  logic              mode_serial,
    input  logic              phase_in,
    output fields_t           fields
);
    always_comb begin
        fields.blank  = word[BLANK_LSB +: BLANK_W];
        fields.torque = word[TORQ_LSB +: TORQ_W];
        fields.decay  = word[DECAY_LSB +: DECAY_W];
        if (mode_serial) begin
            fields.current = word[CUR_LSB +: CUR_W];
            fields.dir     = word[DIR_BIT];
        end else begin
            fields.current = '1;
            fields.dir     = phase_in;
        end
    end

    // R6: pin-PWM mode forces full-scale current and pin direction
    assert_pwm_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_serial |-> (fields.current == '1 && fields.dir == phase_in))
        else $error("pin-PWM forcing broken");

    // R7: serial mode takes current and direction from the held word
    assert_serial_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_serial |-> (fields.current == word[CUR_LSB +: CUR_W] && fields.dir == word[DIR_BIT]))
        else $error("serial fields broken");
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import sdcr_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep,
    input  logic               ser_clk,
    input  logic               ser_data,
    input  logic               ser_strobe,
    input  logic               mode_serial,
    input  logic               phase_in,
    output logic [BLANK_W-1:0] blank_sel,
    output logic [TORQ_W-1:0]  torque_sel,
    output logic [DECAY_W-1:0] decay_sel,
    output logic [CUR_W-1:0]   current_code,
    output logic               dir_out
);
    logic [W-1:0] sr_q;
    logic [W-1:0] sr_next;
    logic [W-1:0] word_q;
    fields_t      fields;
    logic         unused_top;

    sdcr_shifter #(.W(W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (sleep),
        .ser_clk (ser_clk),
        .ser_data(ser_data),
        .sr_q    (sr_q),
        .sr_next (sr_next)
    );

    sdcr_hold #(.W(W)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (sleep),
        .strobe (ser_strobe),
        .sr_next(sr_next),
        .word_q (word_q)
    );

    sdcr_decode u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .word       (word_q[USED_W-1:0]),
        .mode_serial(mode_serial),
        .phase_in   (phase_in),
        .fields     (fields)
    );

    assign unused_top   = ^word_q[W-1:USED_W];
    assign blank_sel    = fields.blank;
    assign torque_sel   = fields.torque;
    assign decay_sel    = fields.decay;
    assign current_code = fields.current;
    assign dir_out      = fields.dir;

    // R3: with the strobe low, the held word tracks the shift register
    assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_strobe && !sleep) |=> (word_q == sr_q))
        else $error("held word does not follow shift register");

    // R8: sleep also clears the shift register
    assert_sleep_sr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (sr_q == RESET_WORD[W-1:0]))
        else $error("shift register not cleared");
endmodule

// File: tb/serial_cfg_port_test.sv
module serial_cfg_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_strobe = 1'b1;
    logic       mode_serial = 1'b1;
    logic       phase_in = 1'b0;
    logic [2:0] blank_sel;
    logic [1:0] torque_sel;
    logic [1:0] decay_sel;
    logic [4:0] current_code;
    logic       dir_out;

    int n_checks = 0;
    int n_fail = 0;
    logic [15:0] model_sr = 16'h0FB8;
    logic [15:0] model_word = 16'h0FB8;
    bit done = 0;

    always #5 clk = ~clk;

    serial_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .ser_clk(ser_clk),
        .ser_data(ser_data), .ser_strobe(ser_strobe), .mode_serial(mode_serial),
        .phase_in(phase_in), .blank_sel(blank_sel), .torque_sel(torque_sel),
        .decay_sel(decay_sel), .current_code(current_code), .dir_out(dir_out)
    );

    function automatic logic [12:0] expect_out(logic [15:0] w, logic m, logic p);
        return {w[2:0], w[4:3], w[6:5], (m ? w[11:7] : 5'h1f), (m ? w[12] : p)};
    endfunction

    task automatic check(string tag);
        logic [12:0] act;
        logic [12:0] exp;
        act = {blank_sel, torque_sel, decay_sel, current_code, dir_out};
        exp = expect_out(model_word, mode_serial, phase_in);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %h expected %h", tag, act, exp);
        end
    endtask

    task automatic shift_bit(logic b);
        @(negedge clk);
        ser_data = b;
        ser_clk  = 1'b1;
        @(negedge clk);
        ser_clk  = 1'b0;
        model_sr = {b, model_sr[15:1]};
        if (!ser_strobe) model_word = model_sr;
    endtask

    task automatic shift_frame(logic [15:0] w);
        for (int i = 0; i < 16; i++) shift_bit(w[i]);
    endtask

    task automatic load_pulse();
        @(negedge clk);
        ser_strobe = 1'b0;
        @(negedge clk);
        ser_strobe = 1'b1;
        model_word = model_sr;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: timeout");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset defaults
        check("R1 reset word");
        if (current_code !== 5'd31 || torque_sel !== 2'd3 || decay_sel !== 2'd1) begin
            n_fail++;
            $display("FAIL R1: cur %0d torq %0d decay %0d expected 31 3 1",
                     current_code, torque_sel, decay_sel);
        end
        n_checks++;

        // R4: shifting under a high strobe is invisible
        shift_frame(16'h1A55);
        check("R4 hold during shift");
        // R2 R5: frame lands bit 0 first
        load_pulse();
        check("R2 R5 frame 1A55");
        if (blank_sel !== 3'd5 || current_code !== 5'd20 || dir_out !== 1'b1) begin
            n_fail++;
            $display("FAIL R5: blank %0d cur %0d dir %0d expected 5 20 1",
                     blank_sel, current_code, dir_out);
        end
        n_checks++;

        // R6: pin-PWM mode
        mode_serial = 1'b0;
        phase_in = 1'b0;
        @(negedge clk);
        check("R6 pwm phase0");
        phase_in = 1'b1;
        @(negedge clk);
        check("R6 pwm phase1");
        mode_serial = 1'b1;
        @(negedge clk);
        check("R7 serial again");

        // R9: upper bits toggled only
        shift_frame(16'hFA55);
        load_pulse();
        check("R9 upper bits set");
        if (current_code !== 5'd20 || dir_out !== 1'b1 || blank_sel !== 3'd5) begin
            n_fail++;
            $display("FAIL R9: cur %0d dir %0d blank %0d expected 20 1 5",
                     current_code, dir_out, blank_sel);
        end
        n_checks++;

        // R3: transparent while strobe low, bit by bit
        @(negedge clk);
        ser_strobe = 1'b0;
        model_word = model_sr;
        for (int i = 0; i < 16; i++) begin
            shift_bit(1'($urandom_range(0, 1)));
            check("R3 follow per bit");
        end
        @(negedge clk);
        ser_strobe = 1'b1;
        @(negedge clk);
        // R4: frozen after rising edge
        shift_frame(16'h0000);
        check("R4 frozen after capture");

        // R8: sleep clears shift register and held word
        @(negedge clk);
        sleep = 1'b1;
        @(negedge clk);
        sleep = 1'b0;
        model_sr = 16'h0FB8;
        model_word = 16'h0FB8;
        check("R8 sleep clears held word");
        load_pulse();
        check("R8 sleep clears shift register");

        // random frames, modes and phases
        for (int k = 0; k < 40; k++) begin
            w = 16'($urandom);
            shift_frame(w);
            check("R4 random hold");
            load_pulse();
            mode_serial = 1'($urandom_range(0, 1));
            phase_in = 1'($urandom_range(0, 1));
            @(negedge clk);
            check(mode_serial ? "R7 random serial" : "R6 random pwm");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule